// File: doc/BRIEF.md
# Processor Status Word Write and Read Unit

This block keeps the processor's current status word together with one saved status word for each exception mode that has one. A move-to-status operation updates either the current word or the saved word of the present mode. A four-bit field mask picks which byte lanes take the new data. A move-from-status operation returns either word on a combinational read port. Instruction decode happens upstream, so the block sees only an enable, a current/saved select, the lane mask and the data.

The current mode is taken from the low five bits of the current word, so mode changes are made with control-lane writes. Privilege limits what a write can reach. In user mode only the four condition flags can change. Modes without a saved word return zero when it is read and drop any write aimed at it. Bits that have no meaning always read as zero. A write that would put an unknown mode code into a word leaves that word's mode field as it was.

The block has no streaming data path. Every pin is a plain control or status signal, with no handshake and no back-pressure.

Top module: `sw_status_unit`

## Requirements
- R1: After reset the current word is 0x000000D3 (supervisor mode with both interrupt masks set) and every saved word is zero.
- R2: `field_mask` bit 0 selects bits 7:0, bit 1 selects bits 15:8, bit 2 selects bits 23:16 and bit 3 selects bits 31:24. On a write only the selected lanes take `wr_data`; all other bits keep their values.
- R3: Bits 27:8 of every word always read as zero, whatever `wr_data` carries. The live bits are the flags in 31:28, I in 7, F in 6, T in 5 and the mode in 4:0.
- R4: In any mode other than user, a write with `sel_saved`=0 may change every lane of the current word.
- R5: In user mode (10000), a write with `sel_saved`=0 changes only bits 31:28 of the current word, whatever the mask holds.
- R6: The mode codes are user 10000, FIQ 10001, IRQ 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. If a write would store any other code, the mode field of the target word keeps its previous value, while the other written bits still update.
- R7: FIQ, IRQ, supervisor, abort and undefined modes each own one saved word. With `sel_saved`=1, reads and writes reach only the saved word of the current mode.
- R8: In user and system modes a read with `sel_saved`=1 returns zero, and a write with `sel_saved`=1 changes nothing.
- R9: `rd_data` is combinational and shows the selected word in the same cycle. A write becomes visible after the next rising clock edge.
- R10: While `wr_en` is low, neither the current word nor any saved word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Perform a move-to-status write this cycle |
| sel_saved | input | 1 | 0 = current word, 1 = saved word of the current mode (used by both read and write) |
| field_mask | input | 4 | Byte-lane select: bit 0 = control, 1 = extension, 2 = status, 3 = flags |
| wr_data | input | 32 | Data for the selected lanes |
| rd_data | output | 32 | Move-from-status read result |
| status_word | output | 32 | Current status word |

## Verification
The saved words are hard to reach from the ports. Each one can be addressed only while the current word is in its mode, so the stimulus moves the block between modes with control-lane writes. It loads one saved word, switches away and back, and confirms that the other words were left alone. The stimulus then enters system mode and finally user mode. User mode comes last because no write can leave it. This tests the ignored saved-word writes and the flag-only current writes where they apply. An unknown mode code is written while privileged to show that the mode field holds its value while the I, F and T bits in the same lane update.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int WORD_W  = 32;
  localparam int LANE_W  = 8;
  localparam int N_LANES = WORD_W / LANE_W;
  localparam int MODE_W  = 5;
  localparam int N_BANKS = 5;
  localparam int IDX_W   = $clog2(N_BANKS);

  localparam logic [WORD_W-1:0] LIVE_BITS  = 32'hF000_00FF;
  localparam logic [WORD_W-1:0] RESET_WORD = 32'h0000_00D3;
  localparam logic [N_LANES-1:0] FLAG_LANE = N_LANES'(1) << (N_LANES - 1);

  typedef enum logic [MODE_W-1:0] {
    M_USR = 5'b10000,
    M_FIQ = 5'b10001,
    M_IRQ = 5'b10010,
    M_SVC = 5'b10011,
    M_ABT = 5'b10111,
    M_UND = 5'b11011,
    M_SYS = 5'b11111
  } mode_e;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    case (m)
      M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic has_bank(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] bank_of(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   return IDX_W'(0);
      M_IRQ:   return IDX_W'(1);
      M_SVC:   return IDX_W'(2);
      M_ABT:   return IDX_W'(3);
      M_UND:   return IDX_W'(4);
      default: return IDX_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/sw_lane_merge.sv
module sw_lane_merge
  import sw_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int LW    = LANE_W,
  parameter int NL    = N_LANES,
  parameter int MW    = MODE_W
) (
  input  logic [W-1:0]  old_word,
  input  logic [W-1:0]  new_word,
  input  logic [NL-1:0] lane_en,
  output logic [W-1:0]  merged
);
  logic [W-1:0] raw;

  generate
    for (genvar g = 0; g < NL; g++) begin : g_lane
      assign raw[g*LW +: LW] = lane_en[g] ? new_word[g*LW +: LW] : old_word[g*LW +: LW];
    end
  endgenerate

  always_comb begin
    merged = raw & LIVE_BITS;
    if (!mode_ok(raw[MW-1:0])) merged[MW-1:0] = old_word[MW-1:0];
  end
endmodule

// File: rtl/sw_saved_bank.sv
module sw_saved_bank
  import sw_pkg::*;
#(
  parameter int NB = N_BANKS,
  parameter int W  = WORD_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_word,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_word
);
  logic [W-1:0] bank_q [NB];

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)                             bank_q[g] <= '0;
        else if (wr_en && wr_idx == IW'(g))     bank_q[g] <= wr_word;
      end
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NB; i++)
      if (rd_idx == IW'(i)) rd_word = bank_q[i];
  end
endmodule

// File: rtl/sw_status_unit.sv
module sw_status_unit
  import sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_saved,
  input  logic [N_LANES-1:0] field_mask,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic [WORD_W-1:0] status_word
);
  logic [WORD_W-1:0]  cur_q, cur_next, saved_word, saved_next;
  logic [MODE_W-1:0]  cur_mode;
  logic               privileged, banked;
  logic [IDX_W-1:0]   bidx;
  logic [N_LANES-1:0] cur_lanes;

  assign cur_mode   = cur_q[MODE_W-1:0];
  assign privileged = (cur_mode != M_USR);
  assign banked     = has_bank(cur_mode);
  assign bidx       = bank_of(cur_mode);
  assign cur_lanes  = privileged ? field_mask : (field_mask & FLAG_LANE);

  sw_lane_merge u_cur_merge (
    .old_word (cur_q),
    .new_word (wr_data),
    .lane_en  (cur_lanes),
    .merged   (cur_next)
  );

  sw_lane_merge u_sav_merge (
    .old_word (saved_word),
    .new_word (wr_data),
    .lane_en  (field_mask),
    .merged   (saved_next)
  );

  sw_saved_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en && sel_saved && banked),
    .wr_idx  (bidx),
    .wr_word (saved_next),
    .rd_idx  (bidx),
    .rd_word (saved_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                    cur_q <= RESET_WORD;
    else if (wr_en && !sel_saved)  cur_q <= cur_next;
  end

  assign rd_data     = sel_saved ? (banked ? saved_word : '0) : cur_q;
  assign status_word = cur_q;
endmodule

// File: rtl/sw_status_chk.sv
module sw_status_chk
  import sw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              sel_saved,
  input logic [N_LANES-1:0] field_mask,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic [WORD_W-1:0] status_word
);
  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_word & ~LIVE_BITS) == '0);

  // R6
  mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_ok(status_word[MODE_W-1:0]));

  // R5
  user_flags_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_saved && status_word[MODE_W-1:0] == M_USR)
      |=> status_word[27:0] == $past(status_word[27:0]));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || sel_saved) |=> $stable(status_word));

  // R8
  no_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_saved && (status_word[MODE_W-1:0] == M_USR || status_word[MODE_W-1:0] == M_SYS))
      |-> rd_data == '0);

  // R2
  flags_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_saved && field_mask[N_LANES-1])
      |=> status_word[31:28] == $past(wr_data[31:28]));

  // R4
  ctrl_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_saved && field_mask[0] && status_word[MODE_W-1:0] != M_USR
     && mode_ok(wr_data[MODE_W-1:0]))
      |=> status_word[7:0] == $past(wr_data[7:0]));
endmodule

bind sw_status_unit sw_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .sel_saved   (sel_saved),
  .field_mask  (field_mask),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .status_word (status_word)
);

// File: tb/sw_status_unit_bench.sv
module sw_status_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        sel_saved = 1'b0;
  logic [3:0]  field_mask = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, status_word;

  sw_status_unit u_sw_status_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel_saved(sel_saved),
    .field_mask(field_mask), .wr_data(wr_data), .rd_data(rd_data),
    .status_word(status_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [31:0] st;
    logic [31:0] rd;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_cur;
  logic [31:0] m_sav [5];

  function automatic bit legal(input logic [4:0] m);
    return m == 5'h10 || m == 5'h11 || m == 5'h12 || m == 5'h13 ||
           m == 5'h17 || m == 5'h1B || m == 5'h1F;
  endfunction

  function automatic int slot(input logic [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] d,
                                       input logic [3:0] fm);
    logic [31:0] r;
    r = o;
    for (int l = 0; l < 4; l++) if (fm[l]) r[l*8 +: 8] = d[l*8 +: 8];
    r = r & 32'hF000_00FF;
    if (!legal(r[4:0])) r[4:0] = o[4:0];
    return r;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // driver: apply one operation, update the model, queue the expected outcome
  task automatic op(input bit we, input bit sel, input logic [3:0] fm,
                    input logic [31:0] d, input string req);
    exp_t e;
    int   s;
    @(negedge clk);
    wr_en = we; sel_saved = sel; field_mask = fm; wr_data = d;
    if (we) begin
      if (!sel) m_cur = mrg(m_cur, d, (m_cur[4:0] == 5'h10) ? (fm & 4'b1000) : fm);
      else begin
        s = slot(m_cur[4:0]);
        if (s >= 0) m_sav[s] = mrg(m_sav[s], d, fm);
      end
    end
    s = slot(m_cur[4:0]);
    e.st  = m_cur;
    e.rd  = sel ? ((s >= 0) ? m_sav[s] : 32'h0) : m_cur;
    e.req = req;
    @(posedge clk);
    #2;
    wr_en = 1'b0;
    q.push_back(e);
  endtask

  // monitor: compare the queued expectation in the middle of the cycle
  always @(posedge clk) begin
    exp_t e;
    #4;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(e.req, "status_word", status_word, e.st);
      check(e.req, "rd_data", rd_data, e.rd);
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    m_cur = 32'h0000_00D3;
    for (int i = 0; i < 5; i++) m_sav[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    op(0, 1, 4'h0, 32'h0, "R1");                 // reset word, supervisor saved is zero
    op(0, 0, 4'h0, 32'h0, "R9");                 // combinational read of current
    op(1, 0, 4'b0001, 32'h0000_009B, "R4");      // into undefined mode, IRQ masked
    op(0, 1, 4'h0, 32'h0, "R7");                 // undefined bank starts at zero
    op(1, 1, 4'b1111, 32'hA000_00D7, "R7");      // load undefined bank
    op(1, 0, 4'b0001, 32'h0000_0093, "R6");      // into supervisor mode
    op(0, 1, 4'h0, 32'h0, "R7");                 // supervisor bank untouched
    op(1, 0, 4'b1111, 32'hFFFF_FF93, "R3");      // reserved bits stay zero
    op(1, 0, 4'b0110, 32'h1234_5678, "R2");      // middle lanes only: no visible change
    op(1, 0, 4'b1000, 32'h5ABC_DEF0, "R2");      // flag lane only
    op(1, 0, 4'b0001, 32'h0000_00F5, "R6");      // unknown mode code: mode held, I/F/T written
    op(1, 0, 4'b0001, 32'h0000_0092, "R6");      // into IRQ mode
    op(0, 1, 4'h0, 32'h0, "R7");                 // IRQ bank zero
    op(1, 1, 4'b0001, 32'h0000_00D1, "R7");      // load IRQ bank
    op(1, 1, 4'b0001, 32'h0000_0015, "R6");      // unknown code into saved word keeps its mode
    op(1, 0, 4'b0001, 32'h0000_009B, "R7");      // back to undefined mode
    op(0, 1, 4'h0, 32'h0, "R7");                 // undefined bank kept its value
    op(0, 0, 4'b1111, 32'hFFFF_FFFF, "R10");     // enable low: nothing moves
    op(0, 1, 4'b1111, 32'h0000_0000, "R10");
    op(1, 0, 4'b0001, 32'h0000_001F, "R8");      // into system mode
    op(0, 1, 4'h0, 32'h0, "R8");                 // no saved word in system mode
    op(1, 1, 4'b1111, 32'h1234_5693, "R8");      // ignored saved write
    op(1, 0, 4'b0001, 32'h0000_0010, "R5");      // into user mode
    op(1, 0, 4'b1111, 32'h3000_00D3, "R5");      // only flags change
    op(1, 0, 4'b0111, 32'hFFFF_FFD3, "R5");      // non-flag lanes blocked
    op(0, 1, 4'h0, 32'h0, "R8");                 // no saved word in user mode
    op(1, 1, 4'b1111, 32'hF000_00D3, "R8");      // ignored saved write
    op(0, 0, 4'h0, 32'h0, "R9");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule